// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog

This block is a watchdog timer driven through a single write-only-effective control word and observed through a status word. The control word carries a reload count, an enable bit and a 7-bit key. Once the watchdog is enabled, software can only restart or stop it by writing a key that is the bitwise inverse of the key last accepted. Every service write therefore alternates the key, and a runaway loop that keeps writing one fixed value cannot keep the timer alive.

The counter steps down at a slow fixed tick rate derived from the system clock. When it runs out the first time, the block raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out with no valid restart, the block emits a one-cycle system reset request and stops. A valid restart at any point lowers the interrupt and returns the block to the first stage.

Top module: `wdg_keyed_watchdog`

## Requirements
- R1: After reset, the control readback is 0, the status readback is 0, and `nmi_o` and `rst_req_o` are low.
- R2: While the stored enable bit (control bit 8) is 0, a write to the control offset 0x40 is accepted whatever its key. Its low 16 bits become the stored control word, which reads back at 0x40 with bits 31:16 as zero.
- R3: While the stored enable bit is 1, a control write is accepted only if its bits 15:9 equal the bitwise inverse of the stored bits 15:9. A write that fails this test changes neither the control readback nor the status readback.
- R4: An accepted write with bit 8 set loads the counter from bits 8:0 of the written value (bit 8 included, so the count is 256 plus bits 7:0), starts it, and restarts the tick phase. The first expiry then occurs exactly count x (CLK_HZ/TICK_HZ) clock cycles after the write edge.
- R5: An accepted write with bit 8 clear stops the counter, which holds its value. It also lowers `nmi_o` and clears the stage flag.
- R6: The counter decrements by one every CLK_HZ/TICK_HZ clock cycles. Status at offset 0x44 returns the count in bits 8:0, the stage flag in bit 9 and the running flag in bit 10, with every other bit zero.
- R7: When a tick finds the count at 1 or 0 in the first stage, `nmi_o` rises, status bit 9 sets and the counter reloads GRACE (10).
- R8: When a tick finds the count at 1 or 0 in the grace stage, `rst_req_o` pulses high for exactly one cycle, the counter stops at 0 and `nmi_o` stays high.
- R9: An accepted restart lowers `nmi_o` on the next cycle, clears the stage flag and prevents the pending reset request.
- R10: Writes to any offset other than 0x40 change nothing, and reads of any offset other than 0x40 or 0x44 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | ADDR_W | Read byte offset |
| bus_rdata | output | 32 | Read data, combinational from bus_raddr |
| nmi_o | output | 1 | Non-maskable interrupt, high from first expiry |
| rst_req_o | output | 1 | One-cycle system reset request on second expiry |

## Verification
The hardest state to reach is a restart that arrives while the block is in the grace stage, or a write with a wrong key that arrives mid-count. Both need the counter to have been run to a precise point first. The bench uses a small tick divider and counts clock cycles from each accepted write to each expiry, and it keeps a model of the stored key so that it can issue a matching or a deliberately failing key at a known count. It sweeps several reload values through both expiry stages. It then performs restarts and stops in the grace stage, and after each one it checks that the reset request stays silent and that the count holds or reloads as expected.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int CNT_W   = 9;
   localparam int KEY_W   = 7;
   localparam int EN_BIT  = 8;
   localparam int CTRL_W  = 16;
   localparam int KEY_LSB = CTRL_W - KEY_W;

   localparam int STAT_STAGE_BIT = 9;
   localparam int STAT_RUN_BIT   = 10;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_GRACE = 2'd2,
      ST_FIRED = 2'd3
   } wdg_stage_e;
endpackage

// File: rtl/wdg_keygate.sv
module wdg_keygate #(
   parameter int CTRL_W    = 16,
   parameter int KEY_W     = 7,
   parameter int EN_BIT    = 8,
   parameter bit KEY_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [CTRL_W-1:0] wdata,
   output logic              accept,
   output logic [CTRL_W-1:0] ctrl_q
);
   localparam int KEY_LSB = CTRL_W - KEY_W;

   logic [KEY_W-1:0] key_held;
   logic [KEY_W-1:0] key_new;
   logic             armed;

   assign key_held = ctrl_q[CTRL_W-1:KEY_LSB];
   assign key_new  = wdata[CTRL_W-1:KEY_LSB];
   assign armed    = ctrl_q[EN_BIT];

   generate
      if (KEY_CHECK) begin : g_keyed
         // enabled: only the inverse of the held key unlocks a write
         assign accept = wr_hit && (!armed || (key_new == ~key_held));
      end else begin : g_open
         logic unused_key;
         assign unused_key = ^{key_held, key_new, armed};
         assign accept = wr_hit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (accept) begin
         ctrl_q <= wdata;
      end
   end
endmodule

// File: rtl/wdg_tick.sv
module wdg_tick #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_every
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tick = run && !clr;
      end else begin : g_div
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] phase_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               phase_q <= '0;
            end else if (run) begin
               phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            end
         end

         assign tick = run && !clr && (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage
   import wdg_pkg::*;
#(
   parameter int CNT_W = 9,
   parameter int GRACE = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output wdg_stage_e       stage_q,
   output logic             running,
   output logic             nmi,
   output logic             rst_req
);
   localparam logic [CNT_W-1:0] GRACE_V = CNT_W'(GRACE);

   logic expire;

   assign running = (stage_q == ST_ARMED) || (stage_q == ST_GRACE);
   assign nmi     = (stage_q == ST_GRACE) || (stage_q == ST_FIRED);
   assign expire  = tick && running && (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= ST_IDLE;
         cnt_q   <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (load) begin
            if (load_en) begin
               stage_q <= ST_ARMED;
               cnt_q   <= load_cnt;
            end else begin
               stage_q <= ST_IDLE;
            end
         end else if (expire) begin
            if (stage_q == ST_ARMED) begin
               stage_q <= ST_GRACE;
               cnt_q   <= GRACE_V;
            end else begin
               stage_q <= ST_FIRED;
               cnt_q   <= '0;
               rst_req <= 1'b1;
            end
         end else if (tick && running) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdg_keyed_watchdog.sv
module wdg_keyed_watchdog
   import wdg_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 100_000_000,
   parameter int unsigned TICK_HZ = 760,
   parameter int          GRACE   = 10,
   parameter int          ADDR_W  = 8,
   parameter bit          KEY_CHECK = 1'b1,
   parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'('h40),
   parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'('h44)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [ADDR_W-1:0] bus_raddr,
   output logic [31:0]       bus_rdata,
   output logic              nmi_o,
   output logic              rst_req_o
);
   localparam int unsigned DIV = (TICK_HZ == 0) ? 1 : CLK_HZ / TICK_HZ;

   if (TICK_HZ == 0 || CLK_HZ < TICK_HZ) begin : g_bad_rate
      $error("tick rate must be nonzero and not above the clock rate");
   end
   if (GRACE < 1 || GRACE >= (1 << CNT_W)) begin : g_bad_grace
      $error("grace count must fit the counter and be nonzero");
   end
   if (CTRL_OFS == STAT_OFS) begin : g_bad_map
      $error("control and status offsets must differ");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("address width too small");
   end

   logic              wr_hit;
   logic              accept;
   logic [CTRL_W-1:0] ctrl_q;
   logic              tick;
   logic [CNT_W-1:0]  cnt_q;
   wdg_stage_e        stage_q;
   logic              running;
   logic              nmi;
   logic [31:0]       stat_w;
   logic              unused_hi;

   assign wr_hit    = bus_wr && (bus_addr == CTRL_OFS);
   assign unused_hi = ^bus_wdata[31:CTRL_W];

   wdg_keygate #(
      .CTRL_W    (CTRL_W),
      .KEY_W     (KEY_W),
      .EN_BIT    (EN_BIT),
      .KEY_CHECK (KEY_CHECK)
   ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .wdata  (bus_wdata[CTRL_W-1:0]),
      .accept (accept),
      .ctrl_q (ctrl_q)
   );

   wdg_tick #(
      .DIV (DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .clr   (accept),
      .tick  (tick)
   );

   wdg_stage #(
      .CNT_W (CNT_W),
      .GRACE (GRACE)
   ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_en  (bus_wdata[EN_BIT]),
      .load_cnt (bus_wdata[CNT_W-1:0]),
      .tick     (tick),
      .cnt_q    (cnt_q),
      .stage_q  (stage_q),
      .running  (running),
      .nmi      (nmi),
      .rst_req  (rst_req_o)
   );

   assign nmi_o = nmi;

   always_comb begin
      stat_w                 = '0;
      stat_w[CNT_W-1:0]      = cnt_q;
      stat_w[STAT_STAGE_BIT] = nmi;
      stat_w[STAT_RUN_BIT]   = running;
   end

   always_comb begin
      if (bus_raddr == CTRL_OFS) begin
         bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      end else if (bus_raddr == STAT_OFS) begin
         bus_rdata = stat_w;
      end else begin
         bus_rdata = '0;
      end
   end
endmodule

// File: rtl/wdg_keyed_watchdog_chk.sv
module wdg_keyed_watchdog_chk #(
   parameter int GRACE = 10
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_hit,
   input logic [15:0] wdata,
   input logic        accept,
   input logic [15:0] ctrl_q,
   input logic [8:0]  cnt_q,
   input logic        nmi_o,
   input logic        rst_req_o
);
   // R2
   disabled_write_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !ctrl_q[8]) |=> (ctrl_q == $past(wdata)));

   // R3
   bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && ctrl_q[8] && (wdata[15:9] != ~ctrl_q[15:9])) |=> $stable(ctrl_q));

   // R7
   grace_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_o) |-> (cnt_q == 9'(GRACE)));

   // R8
   reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   // R8
   reset_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> nmi_o);

   // R9
   restart_drops_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!nmi_o && !rst_req_o));
endmodule

bind wdg_keyed_watchdog wdg_keyed_watchdog_chk #(.GRACE(GRACE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_hit    (wr_hit),
   .wdata     (bus_wdata[15:0]),
   .accept    (accept),
   .ctrl_q    (ctrl_q),
   .cnt_q     (cnt_q),
   .nmi_o     (nmi_o),
   .rst_req_o (rst_req_o)
);

// File: tb/tb_wdg_keyed_watchdog.sv
module tb_wdg_keyed_watchdog;
   localparam int P = 4;
   localparam int G = 10;
   localparam logic [7:0] A_CTRL = 8'h40;
   localparam logic [7:0] A_STAT = 8'h44;
   localparam logic [31:0] RUNB = 32'h400;
   localparam logic [31:0] STGB = 32'h200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [7:0]  bus_raddr = '0;
   logic [31:0] bus_rdata;
   logic        nmi_o;
   logic        rst_req_o;

   int total = 0;
   int bad = 0;
   logic [6:0]  cur_key = '0;
   logic        cur_en = 1'b0;
   logic [15:0] cur_ctrl = '0;

   always #5 clk = ~clk;

   wdg_keyed_watchdog #(.CLK_HZ(3040), .TICK_HZ(760), .GRACE(G)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
      .nmi_o(nmi_o), .rst_req_o(rst_req_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_raddr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_ctrl(input logic [6:0] key, input logic en, input logic [7:0] low);
      logic [31:0] d;
      d = {16'hC3A5, key, en, low};
      if (!cur_en || key == ~cur_key) begin
         cur_key = key; cur_en = en; cur_ctrl = d[15:0];
      end
      wr(A_CTRL, d);
   endtask

   task automatic until_nmi(inout int k);
      while (!nmi_o && k < 5000) begin @(negedge clk); k++; end
   endtask

   task automatic until_rst(inout int k);
      while (!rst_req_o && k < 5000) begin @(negedge clk); k++; end
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int k;
      int lows[5] = '{0, 1, 3, 7, 40};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, d); chk("R1 ctrl", d, 0);
      rd(A_STAT, d); chk("R1 stat", d, 0);
      chk("R1 nmi", {31'b0, nmi_o}, 0);
      chk("R1 rst_req", {31'b0, rst_req_o}, 0);

      // R10 stray write and read
      wr(8'h48, 32'hFFFF_FFFF);
      rd(A_CTRL, d); chk("R10 stray write", d, 0);
      rd(8'h48, d);  chk("R10 stray read", d, 0);

      // R2 disabled writes take any key
      for (int kk = 0; kk < 128; kk += 19) begin
         wr_ctrl(7'(kk), 1'b0, 8'(kk * 3));
         rd(A_CTRL, d); chk("R2 readback", d, {16'h0, cur_ctrl});
         rd(A_STAT, d); chk("R5 stopped", d, 0);
      end

      // R4 R6 R7 R8 expiry sweep
      for (int i = 0; i < 5; i++) begin
         int n;
         n = 256 + lows[i];
         wr_ctrl(~cur_key, 1'b1, 8'(lows[i]));
         rd(A_STAT, d); chk("R4 load", d, RUNB | 32'(n));
         repeat (2 * P) @(negedge clk);
         rd(A_STAT, d); chk("R6 step", d, RUNB | 32'(n - 2));
         k = 2 * P;
         until_nmi(k);
         chk("R4 first expiry cycles", 32'(k), 32'(n * P));
         rd(A_STAT, d); chk("R7 grace", d, RUNB | STGB | 32'(G));
         k = 0;
         until_rst(k);
         chk("R8 grace cycles", 32'(k), 32'(G * P));
         @(negedge clk);
         chk("R8 pulse width", {31'b0, rst_req_o}, 0);
         chk("R8 nmi held", {31'b0, nmi_o}, 1);
         rd(A_STAT, d); chk("R8 stopped", d, STGB);
      end

      // R3 wrong key after firing
      wr_ctrl(cur_key, 1'b1, 8'd5);
      rd(A_CTRL, d); chk("R3 ctrl kept", d, {16'h0, cur_ctrl});
      rd(A_STAT, d); chk("R3 stat kept", d, STGB);
      chk("R3 nmi kept", {31'b0, nmi_o}, 1);

      // R9 valid restart
      wr_ctrl(~cur_key, 1'b1, 8'd5);
      chk("R9 nmi low", {31'b0, nmi_o}, 0);
      rd(A_STAT, d); chk("R9 stage clear", d, RUNB | 32'd261);
      repeat (3 * P) @(negedge clk);
      rd(A_STAT, d); chk("R6 mid count", d, RUNB | 32'd258);
      wr_ctrl(cur_key, 1'b1, 8'd99);
      rd(A_STAT, d); chk("R3 count kept", d, RUNB | 32'd258);
      rd(A_CTRL, d); chk("R3 ctrl kept mid", d, {16'h0, cur_ctrl});

      // R4 restart mid count postpones expiry
      wr_ctrl(~cur_key, 1'b1, 8'd2);
      k = 0; until_nmi(k);
      chk("R4 restart cycles", 32'(k), 32'(258 * P));

      // R9 restart inside grace
      wr_ctrl(~cur_key, 1'b1, 8'd0);
      chk("R9 grace nmi low", {31'b0, nmi_o}, 0);
      rd(A_STAT, d); chk("R9 grace reload", d, RUNB | 32'd256);
      k = 0;
      while (!nmi_o && k < 5000) begin
         @(negedge clk); k++;
         if (rst_req_o) chk("R9 no reset", 1, 0);
      end
      chk("R9 second run cycles", 32'(k), 32'(256 * P));

      // R5 stop inside grace
      wr_ctrl(~cur_key, 1'b0, 8'd9);
      chk("R5 nmi low", {31'b0, nmi_o}, 0);
      rd(A_STAT, d); chk("R5 hold", d, 32'(G));
      repeat (3 * P) @(negedge clk);
      rd(A_STAT, d); chk("R5 still hold", d, 32'(G));
      chk("R5 no reset", {31'b0, rst_req_o}, 0);
      rd(A_CTRL, d); chk("R5 ctrl", d, {16'h0, cur_ctrl});

      // R2 any key once disabled
      wr_ctrl(cur_key, 1'b1, 8'd1);
      rd(A_CTRL, d); chk("R2 same key when off", d, {16'h0, cur_ctrl});
      rd(A_STAT, d); chk("R2 started", d, RUNB | 32'd257);

      // R10 write to status offset
      wr(A_STAT, 32'h0000_0000);
      rd(A_CTRL, d); chk("R10 stat write ignored", d, {16'h0, cur_ctrl});

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule